// File: doc/BRIEF.md
# Carrier Sense and Transmit Loopback Controller

This block sits in the media-independent side of a 10/100 Ethernet transceiver. It produces the carrier sense output for the MAC and decides whether the transmitted data should be returned on the receive side. Carrier sense combines two activity sources. Receive activity from the line always raises it. Transmit activity raises it only when the link mode calls for it. When the last activity stops, carrier sense stays high for a fixed number of extra clock cycles, so it falls later than it rises.

The mode inputs are link speed, duplex, and one configuration bit. That bit turns off transmit carrier sense and loopback on 10 Mbps half-duplex links. Loopback is active only on a 10 Mbps half-duplex link with that bit clear. In that mode, the receive data and receive valid outputs carry the transmit nibble and the transmit enable, delayed by one register stage. In every other mode they carry the line-side receive data and valid unchanged. Everything is synchronous to one clock.

Top module: `crs_lpbk_ctrl`

## Requirements
- R1: While rx_act_i is 1, crs_o is 1 in the same cycle, for every combination of speed_100_i, full_dup_i and tx_crs_dis_i.
- R2: While tx_en_i is 1 and full_dup_i is 0, crs_o is 1 in the same cycle if speed_100_i is 1, or if speed_100_i is 0 and tx_crs_dis_i is 0.
- R3: tx_en_i alone never raises crs_o when full_dup_i is 1, or when speed_100_i is 0 and tx_crs_dis_i is 1.
- R4: lpbk_en_o is 1 exactly when speed_100_i is 0, full_dup_i is 0 and tx_crs_dis_i is 0.
- R5: While lpbk_en_o is 1, rxd_o equals the txd_i value sampled at the previous rising clock edge, and rx_dv_o equals the tx_en_i value sampled at that edge. In this mode rxd_line_i and rx_dv_line_i have no effect on either output.
- R6: While lpbk_en_o is 0, rxd_o equals rxd_line_i and rx_dv_o equals rx_dv_line_i in the same cycle. In this mode txd_i and tx_en_i have no effect on either output.
- R7: After the last clock edge at which any qualifying activity (R1, R2) was present, crs_o stays 1 for exactly HOLD_CYC more cycles and then goes to 0. This holds for both receive and transmit activity, so in loopback crs_o falls later than tx_en_i.
- R8: When receive and transmit activity overlap, crs_o stays 1 without a gap. It is released HOLD_CYC cycles after the later of the two activities ends.
- R9: While rst_ni is 0, the hold counters and the loopback registers are cleared. After reset, with no activity present, crs_o is 0. In loopback mode, rx_dv_o is 0 until tx_en_i has been sampled high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable from the MAC |
| txd_i | input | DW | Transmit nibble from the MAC |
| rx_act_i | input | 1 | Receive activity from the line |
| rxd_line_i | input | DW | Receive nibble from the line decoder |
| rx_dv_line_i | input | 1 | Receive valid from the line decoder |
| speed_100_i | input | 1 | 1 = 100 Mbps, 0 = 10 Mbps |
| full_dup_i | input | 1 | 1 = full duplex, 0 = half duplex |
| tx_crs_dis_i | input | 1 | At 10 Mbps, 1 disables transmit carrier sense and loopback |
| crs_o | output | 1 | Carrier sense to the MAC |
| lpbk_en_o | output | 1 | Transmit-to-receive loopback is active |
| rxd_o | output | DW | Receive nibble to the MAC |
| rx_dv_o | output | 1 | Receive valid to the MAC |

## Verification
The hardest situation to reach from the ports is the overlap of two hold windows. Receive activity must end while transmit activity is still present, and the carrier must then be released only after the later window expires. The overlap test runs in a 100 Mbps half-duplex mode. It raises rx_act_i, then raises tx_en_i two cycles before rx_act_i drops, and then drops tx_en_i. It checks carrier sense at every cycle and counts the trailing hold cycles. A second hard case is that the line inputs are ignored during loopback. To reach it, the bench drives the line nibble and valid to values that differ from the transmit stream while loopback is active.

// File: rtl/crs_pkg.sv
package crs_pkg;
  typedef struct packed {
    logic spd_100;
    logic full_dup;
    logic tx_crs_dis;
  } link_mode_t;

  function automatic logic tx_crs_allowed(link_mode_t m);
    return !m.full_dup && (m.spd_100 || !m.tx_crs_dis);
  endfunction

  function automatic logic lpbk_allowed(link_mode_t m);
    return !m.full_dup && !m.spd_100 && !m.tx_crs_dis;
  endfunction
endpackage

// File: rtl/crs_mode_dec.sv
module crs_mode_dec
  import crs_pkg::*;
(
  input  link_mode_t mode_i,
  output logic       tx_crs_en_o,
  output logic       lpbk_en_o
);
  assign tx_crs_en_o = tx_crs_allowed(mode_i);
  assign lpbk_en_o   = lpbk_allowed(mode_i);
endmodule

// File: rtl/crs_hold_ctr.sv
module crs_hold_ctr #(
  parameter int unsigned HOLD_CYC = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic act_i,
  output logic hold_o
);
  localparam int unsigned CW = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;
  localparam logic [CW-1:0] LOAD = CW'(HOLD_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (act_i)          cnt_q <= LOAD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  // rise with no delay, fall after HOLD_CYC idle edges
  assign hold_o = act_i | (cnt_q != '0);
endmodule

// File: rtl/crs_lpbk_path.sv
module crs_lpbk_path #(
  parameter int unsigned DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          sel_lpbk_i,
  input  logic          tx_en_i,
  input  logic [DW-1:0] txd_i,
  input  logic          rx_dv_line_i,
  input  logic [DW-1:0] rxd_line_i,
  output logic          rx_dv_o,
  output logic [DW-1:0] rxd_o
);
  logic          tx_en_q;
  logic [DW-1:0] txd_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_en_q <= 1'b0;
      txd_q   <= '0;
    end else begin
      tx_en_q <= tx_en_i;
      txd_q   <= txd_i;
    end
  end

  assign rx_dv_o = sel_lpbk_i ? tx_en_q : rx_dv_line_i;
  assign rxd_o   = sel_lpbk_i ? txd_q   : rxd_line_i;
endmodule

// File: rtl/crs_lpbk_ctrl.sv
module crs_lpbk_ctrl
  import crs_pkg::*;
#(
  parameter int unsigned HOLD_CYC = 2,
  parameter int unsigned DW       = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tx_en_i,
  input  logic [DW-1:0] txd_i,
  input  logic          rx_act_i,
  input  logic [DW-1:0] rxd_line_i,
  input  logic          rx_dv_line_i,
  input  logic          speed_100_i,
  input  logic          full_dup_i,
  input  logic          tx_crs_dis_i,
  output logic          crs_o,
  output logic          lpbk_en_o,
  output logic [DW-1:0] rxd_o,
  output logic          rx_dv_o
);
  localparam int unsigned NSRC = 2;  // 0: receive, 1: qualified transmit

  link_mode_t      mode;
  logic            tx_crs_en;
  logic [NSRC-1:0] src_act;
  logic [NSRC-1:0] src_hold;

  assign mode = '{spd_100: speed_100_i, full_dup: full_dup_i, tx_crs_dis: tx_crs_dis_i};

  crs_mode_dec i_mode_dec (
    .mode_i      (mode),
    .tx_crs_en_o (tx_crs_en),
    .lpbk_en_o   (lpbk_en_o)
  );

  assign src_act[0] = rx_act_i;
  assign src_act[1] = tx_en_i & tx_crs_en;

  for (genvar g = 0; g < NSRC; g++) begin : g_hold
    crs_hold_ctr #(.HOLD_CYC(HOLD_CYC)) i_hold (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .act_i  (src_act[g]),
      .hold_o (src_hold[g])
    );
  end

  assign crs_o = |src_hold;

  crs_lpbk_path #(.DW(DW)) i_path (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .sel_lpbk_i   (lpbk_en_o),
    .tx_en_i      (tx_en_i),
    .txd_i        (txd_i),
    .rx_dv_line_i (rx_dv_line_i),
    .rxd_line_i   (rxd_line_i),
    .rx_dv_o      (rx_dv_o),
    .rxd_o        (rxd_o)
  );
endmodule

// File: rtl/crs_lpbk_ctrl_chk.sv
module crs_lpbk_ctrl_chk #(
  parameter int unsigned HOLD_CYC = 2,
  parameter int unsigned DW       = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_en_i,
  input logic [DW-1:0] txd_i,
  input logic          rx_act_i,
  input logic          speed_100_i,
  input logic          full_dup_i,
  input logic          tx_crs_dis_i,
  input logic          crs_o,
  input logic          lpbk_en_o,
  input logic [DW-1:0] rxd_o,
  input logic          rx_dv_o
);
  localparam int unsigned QW = (HOLD_CYC > 0) ? $clog2(HOLD_CYC + 1) : 1;
  localparam logic [QW-1:0] QLIM = QW'(HOLD_CYC);

  logic          tx_counts;
  logic          any_act;
  logic [QW-1:0] quiet_q;
  logic          past_ok_q;

  assign tx_counts = tx_en_i && !full_dup_i && (speed_100_i || !tx_crs_dis_i);
  assign any_act   = rx_act_i || tx_counts;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      quiet_q   <= QLIM;
      past_ok_q <= 1'b0;
    end else begin
      past_ok_q <= 1'b1;
      if (any_act)            quiet_q <= '0;
      else if (quiet_q != QLIM) quiet_q <= quiet_q + 1'b1;
    end
  end

  assert_rx_raises_crs_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_act_i |-> crs_o);

  assert_tx_raises_crs_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_counts |-> crs_o);

  assert_no_lpbk_fast_or_fdx_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (speed_100_i || full_dup_i || tx_crs_dis_i) |-> !lpbk_en_o);

  assert_lpbk_data_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok_q && lpbk_en_o) |-> (rxd_o == $past(txd_i) && rx_dv_o == $past(tx_en_i)));

  assert_hold_active_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (quiet_q < QLIM) |-> crs_o);

  assert_hold_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!any_act && quiet_q == QLIM) |-> !crs_o);
endmodule

bind crs_lpbk_ctrl crs_lpbk_ctrl_chk #(.HOLD_CYC(HOLD_CYC), .DW(DW)) i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_en_i      (tx_en_i),
  .txd_i        (txd_i),
  .rx_act_i     (rx_act_i),
  .speed_100_i  (speed_100_i),
  .full_dup_i   (full_dup_i),
  .tx_crs_dis_i (tx_crs_dis_i),
  .crs_o        (crs_o),
  .lpbk_en_o    (lpbk_en_o),
  .rxd_o        (rxd_o),
  .rx_dv_o      (rx_dv_o)
);

// File: tb/test_crs_lpbk_ctrl.sv
`timescale 1ns/1ps
module test_crs_lpbk_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int HOLD = 2;
  localparam int DW = 4;

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic          tx_en_i = 1'b0;
  logic [DW-1:0] txd_i = '0;
  logic          rx_act_i = 1'b0;
  logic [DW-1:0] rxd_line_i = '0;
  logic          rx_dv_line_i = 1'b0;
  logic          speed_100_i = 1'b0;
  logic          full_dup_i = 1'b0;
  logic          tx_crs_dis_i = 1'b0;
  logic          crs_o, lpbk_en_o, rx_dv_o;
  logic [DW-1:0] rxd_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  crs_lpbk_ctrl #(.HOLD_CYC(HOLD), .DW(DW)) i_crs_lpbk_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .tx_en_i(tx_en_i), .txd_i(txd_i),
    .rx_act_i(rx_act_i), .rxd_line_i(rxd_line_i), .rx_dv_line_i(rx_dv_line_i),
    .speed_100_i(speed_100_i), .full_dup_i(full_dup_i), .tx_crs_dis_i(tx_crs_dis_i),
    .crs_o(crs_o), .lpbk_en_o(lpbk_en_o), .rxd_o(rxd_o), .rx_dv_o(rx_dv_o)
  );

  task automatic chk(string tag, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // inputs change at negedge, outputs sampled 1 ns later
  task automatic step();
    @(negedge clk);
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic set_mode(bit spd, bit fdx, bit dis);
    speed_100_i = spd; full_dup_i = fdx; tx_crs_dis_i = dis;
  endtask

  task automatic idle_out();
    tx_en_i = 0; rx_act_i = 0;
    repeat (HOLD + 2) step();
  endtask

  task automatic t_reset();
    settle();
    chk("R9 crs_o in reset", crs_o, 0);
    step(); rst_ni = 1; step(); settle();
    chk("R9 crs_o after reset", crs_o, 0);
    chk("R9 rx_dv_o after reset in loopback", rx_dv_o, 0);
    chk("R4 lpbk_en_o 10M half cfg0", lpbk_en_o, 1);
  endtask

  task automatic t_rx_all_modes();
    for (int m = 0; m < 8; m++) begin
      step(); set_mode(m[2], m[1], m[0]); rx_act_i = 1; settle();
      chk($sformatf("R1 crs_o rx mode %0d", m), crs_o, 1);
      idle_out();
    end
  endtask

  task automatic t_tx_all_modes();
    for (int m = 0; m < 8; m++) begin
      bit spd = m[2], fdx = m[1], dis = m[0];
      bit exp_crs = !fdx && (spd || !dis);
      bit exp_lb = !fdx && !spd && !dis;
      step(); set_mode(spd, fdx, dis); tx_en_i = 1; settle();
      chk($sformatf("%s crs_o tx mode %0d", exp_crs ? "R2" : "R3", m), crs_o, exp_crs);
      chk($sformatf("R4 lpbk_en_o mode %0d", m), lpbk_en_o, exp_lb);
      idle_out();
    end
  endtask

  task automatic count_tail(string tag, int exp);
    int hi = 0;
    settle();
    for (int i = 0; i < HOLD + 4; i++) begin
      if (i > 0) begin step(); settle(); end
      if (crs_o) hi++;
    end
    chk(tag, hi, exp);
  endtask

  task automatic t_hold();
    step(); set_mode(1, 0, 0); rx_act_i = 1;
    repeat (3) step();
    rx_act_i = 0;
    count_tail("R7 rx hold length", HOLD);
    step(); set_mode(0, 0, 0); tx_en_i = 1;
    repeat (3) step();
    tx_en_i = 0;
    count_tail("R7 tx hold length in loopback", HOLD);
    idle_out();
  endtask

  task automatic t_lpbk_data();
    logic [DW-1:0] prev = '0;
    step(); set_mode(0, 0, 0);
    rxd_line_i = 4'hA; rx_dv_line_i = 1;
    for (int k = 0; k < 6; k++) begin
      logic [DW-1:0] v = DW'(k * 3 + 1);
      if (k > 0) step();
      txd_i = v; tx_en_i = 1; settle();
      if (k > 0) begin
        chk($sformatf("R5 rxd_o beat %0d", k), rxd_o, prev);
        chk($sformatf("R5 rx_dv_o beat %0d", k), rx_dv_o, 1);
      end
      prev = v;
    end
    step(); tx_en_i = 0; txd_i = '0; settle();
    chk("R5 last nibble after tx_en drop", rxd_o, prev);
    chk("R5 rx_dv_o one cycle after tx_en drop", rx_dv_o, 1);
    step(); settle();
    chk("R5 rx_dv_o low, line valid ignored", rx_dv_o, 0);
    chk("R5 rxd_o ignores line nibble", rxd_o, 0);
    rx_dv_line_i = 0; rxd_line_i = '0;
    idle_out();
  endtask

  task automatic t_passthrough();
    step(); set_mode(1, 0, 0);
    tx_en_i = 1; txd_i = 4'hF; rxd_line_i = 4'h5; rx_dv_line_i = 1; settle();
    chk("R6 rxd_o follows line", rxd_o, 5);
    chk("R6 rx_dv_o follows line", rx_dv_o, 1);
    step(); rxd_line_i = 4'h9; rx_dv_line_i = 0; settle();
    chk("R6 rxd_o same cycle update", rxd_o, 9);
    chk("R6 rx_dv_o ignores tx_en", rx_dv_o, 0);
    step(); set_mode(0, 1, 0); rxd_line_i = 4'h3; settle();
    chk("R6 rxd_o follows line in full duplex", rxd_o, 3);
    rxd_line_i = '0; tx_en_i = 0; txd_i = '0;
    idle_out();
  endtask

  task automatic t_overlap();
    int gaps = 0;
    step(); set_mode(1, 0, 0); rx_act_i = 1;
    for (int c = 0; c < 6; c++) begin
      if (c > 0) step();
      if (c == 2) tx_en_i = 1;
      if (c == 4) rx_act_i = 0;
      settle();
      if (!crs_o) gaps++;
    end
    chk("R8 no gap during overlap", gaps, 0);
    step(); tx_en_i = 0;
    count_tail("R8 release after later activity", HOLD);
    idle_out();
  endtask

  initial begin
    t_reset();
    t_rx_all_modes();
    t_tx_all_modes();
    t_hold();
    t_lpbk_data();
    t_passthrough();
    t_overlap();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 50000);
    if (!done) begin
      done = 1;
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule